// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the serial-side engine of a 512-byte serial EEPROM. A host drives chip select, serial clock, serial data in and a pause line in SPI mode 0 or 3. The engine oversamples these pins in its own system clock domain. It decodes an 8-bit instruction whose bit 3 carries address bit 8 for array accesses, then a low address byte, then data. It drives the serial output with a separate output enable.

Array reads go to a synchronous 512x8 memory port. Each byte is prefetched one byte ahead, and the address runs on through the whole array. Write data collects in a page latch. When chip select rises at a legal point, the engine hands a one-cycle commit request to a neighbouring protection and status block. That request carries a page image and a byte mask, a new status value, or a latch set or clear. Programming, protection rules and write timing belong to the neighbour. The neighbour feeds back a write-busy flag and the live status byte.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset, so_oe, commit_valid and mem_rd are low. No transaction is accepted and so_oe stays low until cs_n has been seen high at least once since reset.
- R2: The instruction byte is decoded as follows: 0000_x011 reads, 0000_x010 writes, 0x06 sets the latch, 0x04 clears it, 0x05 reads status and 0x01 writes status. For read and write, bit 3 (x) is address bit 8. Any other byte leaves so_oe low and gives no commit for the rest of that selection.
- R3: si is taken on rising sck edges and so changes only after falling sck edges. Every field travels most significant bit first.
- R4: A read returns the byte at the 9-bit address, then the following addresses for as long as clocks continue. The address wraps from 0x1FF to 0x000 and does not stop at page boundaries.
- R5: If wip is high when a read needs the array, the read is dropped: so_oe stays low and mem_rd is not raised. Status reads are still served while wip is high.
- R6: A status read outputs status_in, sampled again at the start of every output byte.
- R7: Write data bytes fill the page latch at the low PAGE_W address bits, and these wrap inside the page. A commit has commit_op=3, commit_addr set to the page base, byte slot i at commit_data[8i+7:8i], and commit_mask bit i set for each slot written.
- R8: A write commits only when cs_n rises after at least one full data byte, with no partial bits after it. Otherwise nothing is committed and the array is unchanged.
- R9: Latch set (commit_op=0) and latch clear (commit_op=1) commit only when cs_n rises right after their 8 bits. A status write commits with commit_op=2 and commit_status equal to the data byte, and only when cs_n rises right after that byte.
- R10: Raising cs_n makes so_oe low and abandons the sequence. The next selection starts again with an instruction byte.
- R11: If hold_n falls while sck is low, the engine pauses at once. If hold_n falls while sck is high, the pause starts at the next falling edge. While paused, sck and si are ignored, and so_oe is low whenever hold_n is low. Raising hold_n while sck is low resumes at the same bit.
- R12: commit_valid lasts exactly one clock, and there is at most one commit per selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| wip | input | 1 | Internal write cycle busy |
| status_in | input | 8 | Live status byte |
| mem_rd | output | 1 | Array read strobe |
| mem_addr | output | 9 | Array read address |
| mem_rdata | input | 8 | Array data, valid the cycle after mem_rd |
| commit_valid | output | 1 | Commit request pulse |
| commit_op | output | 2 | 0 set latch, 1 clear latch, 2 status write, 3 page write |
| commit_addr | output | 9 | Page base address |
| commit_status | output | 8 | New status value |
| commit_data | output | 8*2^PAGE_W | Page image, slot i in byte i |
| commit_mask | output | 2^PAGE_W | Slots written |

## Verification
The bench uses the default PAGE_W=4, which gives 16-byte pages over the fixed 512-byte array. With that value, a 17-byte burst shows the in-page overwrite, a write that starts at slot 14 shows the page wrap in three bytes, and a read from 0x1FE crosses the array top in three bytes. An SCK half period of eight system clocks leaves time for synchronizer latency and the one-cycle memory prefetch. It also lets pause entry be placed at either SCK level.

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine #(
  parameter int PAGE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sck,
  input  logic                       si,
  input  logic                       hold_n,
  output logic                       so,
  output logic                       so_oe,
  input  logic                       wip,
  input  logic [7:0]                 status_in,
  output logic                       mem_rd,
  output logic [8:0]                 mem_addr,
  input  logic [7:0]                 mem_rdata,
  output logic                       commit_valid,
  output logic [1:0]                 commit_op,
  output logic [8:0]                 commit_addr,
  output logic [7:0]                 commit_status,
  output logic [8*(1<<PAGE_W)-1:0]   commit_data,
  output logic [(1<<PAGE_W)-1:0]     commit_mask
);
  localparam int AW = 9;
  localparam int PB = 1 << PAGE_W;

  typedef enum logic [2:0] {PH_OP, PH_ADDR, PH_DATA, PH_DONE, PH_IGN} phase_t;
  typedef enum logic [2:0] {OP_NONE, OP_READ, OP_WRITE, OP_RDSR, OP_WRSR, OP_WREN, OP_WRDI} op_t;

  logic [1:0] cs_sy, sck_sy, si_sy, hold_sy;
  logic       sck_q, act_q, seen_high, paused_q, drive_q, rd_q;
  logic [2:0] bitcnt_q;
  logic [7:0] shreg_q, out_sh, nxt_q, wr_status;
  logic [AW-1:0] addr_q;
  logic [PB-1:0] mask_q;
  logic       so_q;
  phase_t     phase_q, dec_ph;
  op_t        op_q, dec_op;
  logic [7:0] page_q [PB];
  logic [8*PB-1:0] page_flat;

  wire cs_s   = cs_sy[1];
  wire sck_s  = sck_sy[1];
  wire si_s   = si_sy[1];
  wire hold_s = hold_sy[1];

  wire active   = seen_high & ~cs_s;
  wire rise     = active & ~paused_q & sck_s & ~sck_q;
  wire fall     = active & ~paused_q & ~sck_s & sck_q;
  wire last_bit = bitcnt_q == 3'd7;
  wire [7:0] byte_in = {shreg_q[6:0], si_s};
  wire pg_we    = rise & last_bit & (phase_q == PH_DATA) & (op_q == OP_WRITE);
  wire out_step = fall & (phase_q == PH_DATA) & ((op_q == OP_READ) | (op_q == OP_RDSR));
  wire end_evt  = act_q & ~active;
  wire page_ok  = (op_q == OP_WRITE) & (phase_q == PH_DATA) & (bitcnt_q == 3'd0) & (|mask_q);

  assign so    = so_q;
  assign so_oe = drive_q & active & ~paused_q & hold_s;

  for (genvar g = 0; g < PB; g++) begin : g_flat
    assign page_flat[8*g +: 8] = page_q[g];
  end

  always_comb begin
    dec_op = OP_NONE;
    dec_ph = PH_IGN;
    if (byte_in[7:4] == 4'h0 && byte_in[2:0] == 3'b011) begin
      dec_op = OP_READ;  dec_ph = PH_ADDR;
    end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == 3'b010) begin
      dec_op = OP_WRITE; dec_ph = PH_ADDR;
    end else begin
      case (byte_in)
        8'h06:   begin dec_op = OP_WREN; dec_ph = PH_DONE; end
        8'h04:   begin dec_op = OP_WRDI; dec_ph = PH_DONE; end
        8'h05:   begin dec_op = OP_RDSR; dec_ph = PH_DATA; end
        8'h01:   begin dec_op = OP_WRSR; dec_ph = PH_DATA; end
        default: begin dec_op = OP_NONE; dec_ph = PH_IGN;  end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pg_we) page_q[addr_q[PAGE_W-1:0]] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b00; sck_sy <= 2'b00; si_sy <= 2'b00; hold_sy <= 2'b11;
      sck_q <= 1'b0; act_q <= 1'b0; seen_high <= 1'b0;
      paused_q <= 1'b0; drive_q <= 1'b0; rd_q <= 1'b0;
      bitcnt_q <= '0; shreg_q <= '0; out_sh <= '0; nxt_q <= '0; wr_status <= '0;
      addr_q <= '0; mask_q <= '0; so_q <= 1'b0;
      phase_q <= PH_OP; op_q <= OP_NONE;
      mem_rd <= 1'b0; mem_addr <= '0;
      commit_valid <= 1'b0; commit_op <= '0; commit_addr <= '0;
      commit_status <= '0; commit_data <= '0; commit_mask <= '0;
    end else begin
      cs_sy   <= {cs_sy[0], cs_n};
      sck_sy  <= {sck_sy[0], sck};
      si_sy   <= {si_sy[0], si};
      hold_sy <= {hold_sy[0], hold_n};
      sck_q     <= sck_s;
      act_q     <= active;
      seen_high <= seen_high | cs_s;
      mem_rd    <= 1'b0;
      rd_q      <= mem_rd;
      if (rd_q) nxt_q <= mem_rdata;
      commit_valid <= 1'b0;

      if (end_evt) begin
        if (phase_q == PH_DONE) begin
          commit_valid  <= 1'b1;
          commit_status <= wr_status;
          case (op_q)
            OP_WREN: commit_op <= 2'd0;
            OP_WRDI: commit_op <= 2'd1;
            default: commit_op <= 2'd2;
          endcase
        end else if (page_ok) begin
          commit_valid <= 1'b1;
          commit_op    <= 2'd3;
          commit_addr  <= {addr_q[AW-1:PAGE_W], {PAGE_W{1'b0}}};
          commit_data  <= page_flat;
          commit_mask  <= mask_q;
        end
      end

      if (!active) begin
        phase_q  <= PH_OP;
        op_q     <= OP_NONE;
        bitcnt_q <= '0;
        drive_q  <= 1'b0;
        paused_q <= 1'b0;
        mask_q   <= '0;
      end else begin
        if (!paused_q && !hold_s && !sck_s)     paused_q <= 1'b1;
        else if (paused_q && hold_s && !sck_s)  paused_q <= 1'b0;

        if (rise) begin
          shreg_q  <= byte_in;
          bitcnt_q <= bitcnt_q + 3'd1;
          case (phase_q)
            PH_DONE: phase_q <= PH_IGN;
            PH_OP: if (last_bit) begin
              op_q       <= dec_op;
              phase_q    <= dec_ph;
              addr_q[8]  <= byte_in[3];
            end
            PH_ADDR: if (last_bit) begin
              addr_q[7:0] <= byte_in;
              if (op_q == OP_READ && wip) begin
                phase_q <= PH_IGN;
              end else begin
                phase_q <= PH_DATA;
                if (op_q == OP_READ) begin
                  mem_rd   <= 1'b1;
                  mem_addr <= {addr_q[8], byte_in};
                end
              end
            end
            PH_DATA: if (last_bit) begin
              if (op_q == OP_WRITE) begin
                mask_q[addr_q[PAGE_W-1:0]] <= 1'b1;
                addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
              end else if (op_q == OP_WRSR) begin
                wr_status <= byte_in;
                phase_q   <= PH_DONE;
              end
            end
            default: ;
          endcase
        end

        if (out_step) begin
          drive_q <= 1'b1;
          if (bitcnt_q == 3'd0) begin
            if (op_q == OP_RDSR) begin
              so_q   <= status_in[7];
              out_sh <= {status_in[6:0], 1'b0};
            end else if (wip) begin
              phase_q <= PH_IGN;
              drive_q <= 1'b0;
            end else begin
              so_q     <= nxt_q[7];
              out_sh   <= {nxt_q[6:0], 1'b0};
              addr_q   <= addr_q + AW'(1);
              mem_rd   <= 1'b1;
              mem_addr <= addr_q + AW'(1);
            end
          end else begin
            so_q   <= out_sh[7];
            out_sh <= {out_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_high |-> (!so_oe && !mem_rd && !commit_valid)); // R1
  AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (so_q != $past(so_q)) |-> $past(out_step)); // R3
  AST_NO_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !$past(wip)); // R5
  AST_PAGE_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_op == 2'd3) |-> (|commit_mask)); // R7
  AST_COMMIT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> cs_s); // R8
  AST_QUIET_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> !so_oe); // R10
  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_q && $past(paused_q)) |-> ($stable(bitcnt_q) && $stable(phase_q))); // R11
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid); // R12
endmodule

// File: tb/sim_spi_eeprom_engine.sv
`timescale 1ns/1ps
module sim_spi_eeprom_engine;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wip = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic so, so_oe, mem_rd, commit_valid;
  logic [8:0] mem_addr, commit_addr;
  logic [7:0] mem_rdata, commit_status;
  logic [1:0] commit_op;
  logic [127:0] commit_data;
  logic [15:0] commit_mask;

  int checks = 0, failures = 0, ncommit = 0;
  logic [1:0] c_op;
  logic [8:0] c_addr;
  logic [7:0] c_status;
  logic [127:0] c_data;
  logic [15:0] c_mask;
  logic oe_seen, oe_low;
  logic [7:0] bmem [512];

  always #4 clk = ~clk;

  spi_eeprom_engine u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .wip(wip), .status_in(status_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .commit_valid(commit_valid), .commit_op(commit_op), .commit_addr(commit_addr),
    .commit_status(commit_status), .commit_data(commit_data), .commit_mask(commit_mask));

  function automatic logic [7:0] initv(input int a);
    logic [15:0] t;
    t = 16'((a % 256) * 5 + (a / 256) * 90 + 3);
    return t[7:0];
  endfunction

  initial for (int i = 0; i < 512; i++) bmem[i] = initv(i);

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= bmem[mem_addr];
    if (commit_valid) begin
      ncommit <= ncommit + 1;
      c_op <= commit_op; c_addr <= commit_addr; c_status <= commit_status;
      c_data <= commit_data; c_mask <= commit_mask;
      if (commit_op == 2'd3)
        for (int i = 0; i < 16; i++)
          if (commit_mask[i]) bmem[{commit_addr[8:4], i[3:0]}] <= commit_data[8*i +: 8];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    si = b;
    repeat (HALF) @(negedge clk);
    r = so;
    if (so_oe) oe_seen = 1'b1; else oe_low = 1'b1;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic clr; oe_seen = 1'b0; oe_low = 1'b0; endtask
  task automatic sel; cs_n = 1'b0; repeat (HALF) @(negedge clk); endtask
  task automatic desel; repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (12) @(negedge clk); endtask

  task automatic open_cmd(input logic [8:0] a, input logic rd);
    logic [7:0] d;
    sel();
    spi_byte({4'b0, a[8], 2'b01, rd}, d);
    spi_byte(a[7:0], d);
    clr();
  endtask

  task automatic t_unarmed;
    logic [7:0] d;
    clr();
    spi_byte(8'h05, d);
    spi_byte(8'h00, d);
    chk("R1", "so_oe before first deselect", {31'd0, oe_seen}, 0);
    cs_n = 1'b1; repeat (12) @(negedge clk);
    chk("R1", "no commit before arm", ncommit, 0);
  endtask

  task automatic t_rdsr;
    logic [7:0] d;
    status_in = 8'h8C;
    sel(); spi_byte(8'h05, d); clr();
    spi_byte(8'h00, d);
    status_in = 8'h03;
    chk("R6", "status byte 1", d, 8'h8C);
    chk("R3", "so driven through status byte", {31'd0, oe_low}, 0);
    spi_byte(8'h00, d);
    chk("R6", "status byte 2 live", d, 8'h03);
    repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (4) @(negedge clk);
    chk("R10", "so_oe after deselect", {31'd0, so_oe}, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_read_wrap;
    logic [7:0] d;
    open_cmd(9'h1FE, 1'b1);
    spi_byte(8'h00, d); chk("R4", "read 0x1FE", d, initv(9'h1FE));
    spi_byte(8'h00, d); chk("R4", "read 0x1FF", d, initv(9'h1FF));
    spi_byte(8'h00, d); chk("R4", "wrap to 0x000", d, initv(0));
    desel();
    open_cmd(9'h0FE, 1'b1);
    spi_byte(8'h00, d); chk("R2", "A8 clear selects 0x0FE", d, initv(9'h0FE));
    desel();
  endtask

  task automatic t_latch;
    logic [7:0] d;
    int n0;
    n0 = ncommit;
    sel(); spi_byte(8'h06, d); desel();
    chk("R9", "set latch commit count", ncommit, n0 + 1);
    chk("R9", "set latch op", {30'd0, c_op}, 0);
    sel(); spi_byte(8'h04, d); desel();
    chk("R9", "clear latch op", {30'd0, c_op}, 1);
    n0 = ncommit;
    sel(); spi_byte(8'h06, d); spi_bit(1'b0, d[0]); desel();
    chk("R9", "extra bit cancels", ncommit, n0);
    sel(); spi_byte(8'h01, d); spi_byte(8'h0C, d); desel();
    chk("R9", "status write op", {30'd0, c_op}, 2);
    chk("R9", "status write value", {24'd0, c_status}, 8'h0C);
    chk("R12", "one commit per selection", ncommit, n0 + 1);
  endtask

  task automatic t_page;
    logic [7:0] d;
    open_cmd(9'h13E, 1'b0);
    spi_byte(8'hA1, d); spi_byte(8'hB2, d); spi_byte(8'hC3, d);
    desel();
    chk("R7", "page op", {30'd0, c_op}, 3);
    chk("R7", "page base", {23'd0, c_addr}, 9'h130);
    chk("R7", "mask", {16'd0, c_mask}, 16'hC001);
    chk("R7", "slot 14", {24'd0, c_data[8*14 +: 8]}, 8'hA1);
    chk("R7", "slot 0 after wrap", {24'd0, c_data[7:0]}, 8'hC3);
    open_cmd(9'h13E, 1'b1);
    spi_byte(8'h00, d); chk("R7", "readback 0x13E", d, 8'hA1);
    spi_byte(8'h00, d); chk("R7", "readback 0x13F", d, 8'hB2);
    spi_byte(8'h00, d); chk("R4", "read crosses page", d, initv(9'h140));
    desel();
    open_cmd(9'h020, 1'b0);
    for (int i = 0; i < 17; i++) spi_byte(8'(8'h40 + i), d);
    desel();
    chk("R7", "full mask", {16'd0, c_mask}, 16'hFFFF);
    chk("R7", "slot 0 overwritten", {24'd0, c_data[7:0]}, 8'h50);
    chk("R7", "slot 1 kept", {24'd0, c_data[15:8]}, 8'h41);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    int n0;
    n0 = ncommit;
    open_cmd(9'h050, 1'b0);
    spi_byte(8'h99, d);
    for (int i = 0; i < 3; i++) spi_bit(1'b1, d[0]);
    desel();
    chk("R8", "mid-byte deselect no commit", ncommit, n0);
    open_cmd(9'h050, 1'b0);
    desel();
    chk("R8", "no data byte no commit", ncommit, n0);
    open_cmd(9'h050, 1'b1);
    spi_byte(8'h00, d); chk("R8", "array unchanged", d, initv(9'h050));
    desel();
  endtask

  task automatic t_busy;
    logic [7:0] d;
    wip = 1'b1;
    open_cmd(9'h003, 1'b1);
    spi_byte(8'h00, d);
    chk("R5", "read blocked while busy", {31'd0, oe_seen}, 0);
    desel();
    status_in = 8'h01;
    sel(); spi_byte(8'h05, d); spi_byte(8'h00, d); desel();
    chk("R5", "status served while busy", d, 8'h01);
    wip = 1'b0;
  endtask

  task automatic t_unknown;
    logic [7:0] d;
    int n0;
    n0 = ncommit;
    sel(); spi_byte(8'h55, d); clr(); spi_byte(8'h00, d); spi_byte(8'hFF, d); desel();
    chk("R2", "unknown opcode keeps so off", {31'd0, oe_seen}, 0);
    chk("R2", "unknown opcode no commit", ncommit, n0);
  endtask

  task automatic t_hold_read;
    logic [7:0] d;
    open_cmd(9'h010, 1'b1);
    for (int i = 7; i >= 5; i--) spi_bit(1'b0, d[i]);
    repeat (2) @(negedge clk);
    hold_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R11", "so_oe while paused", {31'd0, so_oe}, 0);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 4; i >= 0; i--) spi_bit(1'b0, d[i]);
    chk("R11", "read byte across pause", d, initv(9'h010));
    spi_byte(8'h00, d);
    chk("R11", "next byte after pause", d, initv(9'h011));
    desel();
  endtask

  task automatic t_hold_write;
    logic [7:0] v, d;
    v = 8'h6D;
    open_cmd(9'h0A0, 1'b0);
    for (int i = 7; i >= 4; i--) spi_bit(v[i], d[0]);
    si = v[3];
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    hold_n = 1'b0;
    repeat (HALF - 2) @(negedge clk);
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      si = ~v[2];
      sck = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 2; i >= 0; i--) spi_bit(v[i], d[0]);
    desel();
    chk("R11", "paused write mask", {16'd0, c_mask}, 16'h0001);
    chk("R11", "paused write byte", {24'd0, c_data[7:0]}, 8'h6D);
    chk("R11", "paused write base", {23'd0, c_addr}, 9'h0A0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset so_oe", {31'd0, so_oe}, 0);
    chk("R1", "reset commit_valid", {31'd0, commit_valid}, 0);
    chk("R1", "reset mem_rd", {31'd0, mem_rd}, 0);
    t_unarmed();
    t_rdsr();
    t_read_wrap();
    t_latch();
    t_page();
    t_abort();
    t_busy();
    t_unknown();
    t_hold_read();
    t_hold_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule